// File: doc/BRIEF.md
# Microcode Sequencer with Opcode Dispatch

This block is the control sequencer of a microprogrammed interpreter CPU. It holds the micro program counter that addresses an external microcode ROM, and it receives the full horizontal control word back from that ROM. A small group of low-order fields in the word steers sequencing. The upper bits go straight out to the datapath. The sequencer also holds the 8-bit intermediate-language opcode register and the program counter that addresses the external IL program store. When a microword asks for it, the opcode register is loaded from that store and the IL program counter advances by one.

Each microword names one sequencing action:
- advance to the next address;
- hold the current address while a condition holds, which is used to wait on ready signals;
- conditional jump;
- conditional subroutine call;
- conditional return;
- dispatch on the opcode.

Dispatch looks the opcode up in a mapping table. Every entry of the table starts as the bad-opcode routine address. An ordered list of (match, mask, address) patterns then overrides entries, and a later pattern wins over an earlier one. A looked-up address outside the microcode store, or a fault on the return stack, sends control to a fixed error routine and raises the error flag.

The fetch routine has two entry points, and both are ordinary jump targets. An instruction that overlaps one cycle of fetch work jumps to the second entry point.

The controller has two states. ST_RUN is the normal state. ST_FAULT is entered from ST_RUN on any dispatch or stack fault (transition "fault"). ST_FAULT is left only by reset (transition "reset to ST_RUN"). The microcode keeps running from the error routine while in ST_FAULT.

Top module: `mseq_top`

## Requirements
- R1: Synchronous reset sets upc_o to 0, il_pc_o to 0, opcode_o to 0, err_o to 0 and empties the return stack.
- R2: When load bit uword_i[8] is 1, opcode_o takes il_data_i and il_pc_o increases by one at the next edge. When the bit is 0, both hold their values.
- R3: The branch condition equals cond_i[uword_i[6:3]] XOR uword_i[7].
- R4: Op field uword_i[2:0] = 0 (advance), and the unused codes 6 and 7, set upc_o to upc_o+1. Op 1 (repeat) keeps upc_o while the condition is true and advances it otherwise.
- R5: Op 2 (jump) loads the target field uword_i[16:9] when the condition is true and advances otherwise.
- R6: Op 3 (call) with a true condition pushes upc_o+1 and loads the target. With a false condition it advances and pushes nothing. Op 4 (return) with a true condition loads the most recently pushed address, in LIFO order. With a false condition it advances.
- R7: The return stack holds 4 addresses. A taken call with 4 entries stored, or a taken return with none stored, loads error address 12 and sets err_o.
- R8: Op 5 (dispatch) ignores the condition and loads the map entry for opcode_o. Opcodes map as follows: 0x00 maps to 20; 0x01 to 0x07 map to 14; 0x12 maps to 30; 0xF0 to 0xFF map to 250; every other opcode maps to the bad-opcode address 13. An entry of 240 or above is invalid; it loads address 12 and sets err_o.
- R9: err_o stays 1 until reset, and sequencing continues normally after a fault.
- R10: ctrl_o equals uword_i[79:17] in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uword_i | input | 80 | Microword read from the microcode ROM at upc_o |
| upc_o | output | 8 | Micro program counter (microcode ROM address) |
| cond_i | input | 16 | Condition inputs |
| il_data_i | input | 8 | Opcode byte read from the IL store at il_pc_o |
| il_pc_o | output | 10 | IL program counter |
| opcode_o | output | 8 | Opcode register |
| ctrl_o | output | 63 | Datapath control bits of the current microword |
| err_o | output | 1 | Sticky internal-error flag |

## Verification
upc_o, il_pc_o, opcode_o and err_o are registers. Their response to a microword is due exactly one clock edge after the word is presented. ctrl_o is combinational and is due within the same cycle. The bench drives each word on a falling edge and compares the registered results on the following falling edge, one rising edge later. It reads ctrl_o shortly after driving the word and before any edge. Dispatch is swept over all 256 opcodes, and repeat over every condition select, invert value and input level.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [2:0] {
        OP_NEXT   = 3'd0,
        OP_REPEAT = 3'd1,
        OP_GOTO   = 3'd2,
        OP_CALL   = 3'd3,
        OP_RET    = 3'd4,
        OP_FORK   = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } seq_op_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/mseq_cond.sv
module mseq_cond #(
    parameter int COND_N = 16,
    localparam int SEL_W = $clog2(COND_N)
) (
    input  logic [COND_N-1:0] cond_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              inv_i,
    output logic              hit_o
);
    always_comb begin
        hit_o = cond_i[sel_i] ^ inv_i;
    end
endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch #(
    parameter int OP_W        = 8,
    parameter int UADDR_W     = 8,
    parameter int UCODE_DEPTH = 240,
    parameter int BAD_ADDR    = 13,
    parameter int N_PAT       = 4,
    parameter logic [N_PAT*OP_W-1:0]    PAT_MATCH = '0,
    parameter logic [N_PAT*OP_W-1:0]    PAT_MASK  = '0,
    parameter logic [N_PAT*UADDR_W-1:0] PAT_ADDR  = '0
) (
    input  logic [OP_W-1:0]    opcode_i,
    output logic [UADDR_W-1:0] addr_o,
    output logic               valid_o
);
    // Pattern hits are found in parallel; the highest-numbered hit wins.
    logic [N_PAT-1:0] hit;

    for (genvar g = 0; g < N_PAT; g++) begin : g_pat
        assign hit[g] = ((opcode_i ^ PAT_MATCH[g*OP_W +: OP_W])
                         & PAT_MASK[g*OP_W +: OP_W]) == '0;
    end

    always_comb begin
        addr_o = UADDR_W'(BAD_ADDR);
        for (int i = 0; i < N_PAT; i++) begin
            if (hit[i]) begin
                addr_o = PAT_ADDR[i*UADDR_W +: UADDR_W];
            end
        end
        valid_o = ({1'b0, addr_o} < (UADDR_W+1)'(UCODE_DEPTH));
    end
endmodule

// File: rtl/mseq_rstack.sv
module mseq_rstack #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o,
    output logic         full_o,
    output logic         empty_o
);
    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_idx  = cnt[IDX_W-1:0];
    assign rd_idx  = IDX_W'(cnt - CNT_W'(1));
    assign full_o  = (cnt == CNT_W'(DEPTH));
    assign empty_o = (cnt == '0);
    assign top_o   = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push_i) begin
            cnt <= cnt + CNT_W'(1);
        end else if (pop_i) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (push_i && wr_idx == IDX_W'(g)) begin
                mem[g] <= din_i;
            end
        end
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int UWORD_W     = 80,
    parameter int UADDR_W     = 8,
    parameter int OP_W        = 8,
    parameter int ILPC_W      = 10,
    parameter int COND_N      = 16,
    parameter int STACK_D     = 4,
    parameter int UCODE_DEPTH = 240,
    parameter int ERR_ADDR    = 12,
    parameter int BAD_ADDR    = 13,
    parameter int N_PAT       = 4,
    parameter logic [N_PAT*OP_W-1:0]    PAT_MATCH = {8'hF0, 8'h12, 8'h00, 8'h00},
    parameter logic [N_PAT*OP_W-1:0]    PAT_MASK  = {8'hF0, 8'hFF, 8'hFF, 8'hF8},
    parameter logic [N_PAT*UADDR_W-1:0] PAT_ADDR  = {8'd250, 8'd30, 8'd20, 8'd14},
    localparam int SEL_W     = $clog2(COND_N),
    localparam int F_SEL_LO  = 3,
    localparam int F_INV     = F_SEL_LO + SEL_W,
    localparam int F_LD      = F_INV + 1,
    localparam int F_TGT_LO  = F_LD + 1,
    localparam int F_CTL_LO  = F_TGT_LO + UADDR_W,
    localparam int CTRL_W    = UWORD_W - F_CTL_LO
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [UWORD_W-1:0] uword_i,
    output logic [UADDR_W-1:0] upc_o,
    input  logic [COND_N-1:0]  cond_i,
    input  logic [OP_W-1:0]    il_data_i,
    output logic [ILPC_W-1:0]  il_pc_o,
    output logic [OP_W-1:0]    opcode_o,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic               err_o
);
    // Microword field split
    seq_op_e            op;
    logic [SEL_W-1:0]   sel;
    logic               inv;
    logic               ld;
    logic [UADDR_W-1:0] tgt;

    assign op     = seq_op_e'(uword_i[2:0]);
    assign sel    = uword_i[F_SEL_LO +: SEL_W];
    assign inv    = uword_i[F_INV];
    assign ld     = uword_i[F_LD];
    assign tgt    = uword_i[F_TGT_LO +: UADDR_W];
    assign ctrl_o = uword_i[UWORD_W-1:F_CTL_LO];

    // Registers
    logic [UADDR_W-1:0] upc_q, upc_d, upc_inc;
    logic [ILPC_W-1:0]  ilpc_q;
    logic [OP_W-1:0]    opc_q;
    seq_state_e         state_q, state_d;

    assign upc_inc = upc_q + UADDR_W'(1);

    // Condition selection
    logic cond_hit;
    mseq_cond #(.COND_N(COND_N)) u_cond (
        .cond_i (cond_i),
        .sel_i  (sel),
        .inv_i  (inv),
        .hit_o  (cond_hit)
    );

    // Opcode map
    logic [UADDR_W-1:0] map_addr;
    logic               map_ok;
    mseq_dispatch #(
        .OP_W        (OP_W),
        .UADDR_W     (UADDR_W),
        .UCODE_DEPTH (UCODE_DEPTH),
        .BAD_ADDR    (BAD_ADDR),
        .N_PAT       (N_PAT),
        .PAT_MATCH   (PAT_MATCH),
        .PAT_MASK    (PAT_MASK),
        .PAT_ADDR    (PAT_ADDR)
    ) u_map (
        .opcode_i (opc_q),
        .addr_o   (map_addr),
        .valid_o  (map_ok)
    );

    // Return stack
    logic               push, pop, stk_full, stk_empty;
    logic [UADDR_W-1:0] stk_top;
    mseq_rstack #(.DEPTH(STACK_D), .W(UADDR_W)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .pop_i   (pop),
        .din_i   (upc_inc),
        .top_o   (stk_top),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    // Next-address selection
    logic fault;
    always_comb begin
        upc_d = upc_inc;
        push  = 1'b0;
        pop   = 1'b0;
        fault = 1'b0;
        unique case (op)
            OP_NEXT, OP_RSV6, OP_RSV7: begin
                upc_d = upc_inc;
            end
            OP_REPEAT: begin
                upc_d = cond_hit ? upc_q : upc_inc;
            end
            OP_GOTO: begin
                upc_d = cond_hit ? tgt : upc_inc;
            end
            OP_CALL: begin
                if (cond_hit) begin
                    if (stk_full) begin
                        fault = 1'b1;
                    end else begin
                        push  = 1'b1;
                        upc_d = tgt;
                    end
                end
            end
            OP_RET: begin
                if (cond_hit) begin
                    if (stk_empty) begin
                        fault = 1'b1;
                    end else begin
                        pop   = 1'b1;
                        upc_d = stk_top;
                    end
                end
            end
            OP_FORK: begin
                if (map_ok) begin
                    upc_d = map_addr;
                end else begin
                    fault = 1'b1;
                end
            end
        endcase
        if (fault) begin
            upc_d = UADDR_W'(ERR_ADDR);
        end
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q  <= '0;
            ilpc_q <= '0;
            opc_q  <= '0;
        end else begin
            upc_q <= upc_d;
            if (ld) begin
                opc_q  <= il_data_i;
                ilpc_q <= ilpc_q + ILPC_W'(1);
            end
        end
    end

    // Controller state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:   state_d = fault ? ST_FAULT : ST_RUN;
            ST_FAULT: state_d = ST_FAULT;
        endcase
    end

    // Outputs
    always_comb begin
        upc_o    = upc_q;
        il_pc_o  = ilpc_q;
        opcode_o = opc_q;
        err_o    = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
    parameter int UWORD_W  = 80,
    parameter int UADDR_W  = 8,
    parameter int OP_W     = 8,
    parameter int ILPC_W   = 10,
    parameter int COND_N   = 16,
    parameter int ERR_ADDR = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [UWORD_W-1:0] uword_i,
    input logic [UADDR_W-1:0] upc_o,
    input logic [COND_N-1:0]  cond_i,
    input logic [OP_W-1:0]    il_data_i,
    input logic [ILPC_W-1:0]  il_pc_o,
    input logic [OP_W-1:0]    opcode_o,
    input logic               err_o
);
    localparam int SEL_W    = $clog2(COND_N);
    localparam int F_INV    = 3 + SEL_W;
    localparam int F_LD     = F_INV + 1;
    localparam int F_TGT_LO = F_LD + 1;

    logic [2:0]         op;
    logic               cnd;
    logic               ld;
    logic [UADDR_W-1:0] tgt;
    logic [UADDR_W-1:0] upc_inc;
    logic [ILPC_W-1:0]  ilpc_inc;

    assign op       = uword_i[2:0];
    assign cnd      = cond_i[uword_i[3 +: SEL_W]] ^ uword_i[F_INV];
    assign ld       = uword_i[F_LD];
    assign tgt      = uword_i[F_TGT_LO +: UADDR_W];
    assign upc_inc  = upc_o + UADDR_W'(1);
    assign ilpc_inc = il_pc_o + ILPC_W'(1);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (upc_o == '0 && il_pc_o == '0 && opcode_o == '0 && !err_o));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (opcode_o == $past(il_data_i) && il_pc_o == $past(ilpc_inc)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ld |=> ($stable(opcode_o) && $stable(il_pc_o)));

    assert_repeat_R4: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd1 && cnd) |=> $stable(upc_o));

    assert_next_R4: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd0) |=> (upc_o == $past(upc_inc)));

    assert_goto_R5: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd2 && cnd) |=> (upc_o == $past(tgt)));

    assert_fault_addr_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (upc_o == UADDR_W'(ERR_ADDR)));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind mseq_top mseq_chk #(
    .UWORD_W  (UWORD_W),
    .UADDR_W  (UADDR_W),
    .OP_W     (OP_W),
    .ILPC_W   (ILPC_W),
    .COND_N   (COND_N),
    .ERR_ADDR (ERR_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .uword_i   (uword_i),
    .upc_o     (upc_o),
    .cond_i    (cond_i),
    .il_data_i (il_data_i),
    .il_pc_o   (il_pc_o),
    .opcode_o  (opcode_o),
    .err_o     (err_o)
);

// File: tb/tb_mseq_top.sv
`timescale 1ns/1ps
module tb_mseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [79:0] uword = '0;
    logic [15:0] cond = 16'h0001;
    logic [7:0]  il_data = '0;
    logic [7:0]  upc;
    logic [9:0]  il_pc;
    logic [7:0]  opcode;
    logic [62:0] ctrl;
    logic        err;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mseq_top dut (
        .clk       (clk),
        .rst       (rst),
        .uword_i   (uword),
        .upc_o     (upc),
        .cond_i    (cond),
        .il_data_i (il_data),
        .il_pc_o   (il_pc),
        .opcode_o  (opcode),
        .ctrl_o    (ctrl),
        .err_o     (err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [79:0] mk(input int op, input int sel, input int inv,
                                       input int ld, input int tgt, input logic [62:0] ctl);
        logic [79:0] w;
        w        = '0;
        w[2:0]   = op[2:0];
        w[6:3]   = sel[3:0];
        w[7]     = inv[0];
        w[8]     = ld[0];
        w[16:9]  = tgt[7:0];
        w[79:17] = ctl;
        return w;
    endfunction

    // Called on a falling edge; returns on the next falling edge.
    task automatic step(input logic [79:0] w);
        uword = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        uword = '0;
        cond  = 16'h0001;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int exp_map(input int o);
        if (o >= 8'hF0) return -1;
        if (o == 8'h12) return 30;
        if (o == 0)     return 20;
        if (o < 8)      return 14;
        return 13;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [7:0] rets [4];
        do_reset();

        // R1 reset state
        chk("R1 upc", upc, 0);
        chk("R1 il_pc", il_pc, 0);
        chk("R1 opcode", opcode, 0);
        chk("R1 err", err, 0);

        // R10 control passthrough, same cycle
        uword = mk(0, 0, 0, 0, 0, 63'h5A5A_1234_ABCD_0F0F);
        #1;
        chk("R10 ctrl", ctrl, 63'h5A5A_1234_ABCD_0F0F);
        @(negedge clk);
        do_reset();

        // R4 advance and unused op codes
        step(mk(0, 0, 0, 0, 0, '0)); chk("R4 next", upc, 1);
        step(mk(6, 0, 0, 0, 0, '0)); chk("R4 op6", upc, 2);
        step(mk(7, 0, 0, 0, 0, '0)); chk("R4 op7", upc, 3);

        // R2 opcode load and hold
        il_data = 8'hA5;
        step(mk(0, 0, 0, 1, 0, '0));
        chk("R2 opcode load", opcode, 8'hA5);
        chk("R2 il_pc inc", il_pc, 1);
        il_data = 8'h3C;
        step(mk(0, 0, 0, 0, 0, '0));
        chk("R2 opcode hold", opcode, 8'hA5);
        chk("R2 il_pc hold", il_pc, 1);

        // R5 jump taken (second fetch entry at 1) and not taken
        step(mk(2, 0, 0, 0, 1, '0)); chk("R5 goto taken", upc, 1);
        step(mk(2, 0, 1, 0, 8'h40, '0)); chk("R5 goto not taken", upc, 2);

        // R3 / R4 repeat sweep over select, invert, level
        for (int s = 0; s < 16; s++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int v = 0; v < 2; v++) begin
                    logic t;
                    cond = v ? (16'h1 << s) : ~(16'h1 << s);
                    t = v[0] ^ iv[0];
                    b = upc;
                    step(mk(1, s, iv, 0, 0, '0));
                    chk("R3 R4 repeat", upc, t ? b : b + 8'd1);
                end
            end
        end

        // R6 / R7 call overflow
        do_reset();
        for (int k = 0; k < 4; k++) begin
            step(mk(3, 0, 0, 0, 16 * (k + 1), '0));
            chk("R6 call target", upc, 16 * (k + 1));
        end
        chk("R6 no error yet", err, 0);
        step(mk(3, 0, 0, 0, 8'h70, '0));
        chk("R7 overflow addr", upc, 12);
        chk("R7 overflow err", err, 1);

        // R6 LIFO returns, R7 underflow, R9 sticky
        do_reset();
        for (int k = 0; k < 4; k++) begin
            rets[k] = upc + 8'd1;
            step(mk(3, 0, 0, 0, 16 * (k + 1) + 3, '0));
        end
        for (int k = 3; k >= 0; k--) begin
            step(mk(4, 0, 0, 0, 0, '0));
            chk("R6 return addr", upc, rets[k]);
        end
        chk("R6 err clear", err, 0);
        step(mk(4, 0, 0, 0, 0, '0));
        chk("R7 underflow addr", upc, 12);
        chk("R7 underflow err", err, 1);
        step(mk(0, 0, 0, 0, 0, '0));
        chk("R9 continue", upc, 13);
        chk("R9 sticky", err, 1);
        step(mk(0, 0, 0, 0, 0, '0));
        chk("R9 sticky 2", err, 1);

        // R6 false call pushes nothing
        do_reset();
        step(mk(3, 0, 1, 0, 8'h50, '0)); chk("R6 call false", upc, 1);
        step(mk(4, 0, 0, 0, 0, '0));
        chk("R6 no push addr", upc, 12);
        chk("R6 no push err", err, 1);

        // R6 false return on empty stack is harmless
        do_reset();
        step(mk(4, 0, 1, 0, 0, '0));
        chk("R6 ret false", upc, 1);
        chk("R6 ret false err", err, 0);

        // R8 dispatch sweep over all opcodes, condition forced false
        for (int o = 0; o < 256; o++) begin
            int e;
            do_reset();
            il_data = o[7:0];
            step(mk(0, 0, 0, 1, 0, '0));
            chk("R2 sweep load", opcode, o);
            step(mk(5, 0, 1, 0, 8'h77, '0));
            e = exp_map(o);
            if (e < 0) begin
                chk("R8 invalid addr", upc, 12);
                chk("R8 invalid err", err, 1);
            end else begin
                chk("R8 map addr", upc, e);
                chk("R8 map err", err, 0);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule